// File: doc/BRIEF.md
# I2C Control Register File Slave

This block is a serial-bus target that gives a host controller read and write access to a bank of 8-bit control registers. SCL and SDA are oversampled by the system clock through a two-stage synchronizer; START and STOP are recognised from SDA edges while SCL is high, and the first byte after any START is compared with a fixed 7-bit device address. The least significant bit of that byte selects the direction: 0 for a write, 1 for a read.

In a write transfer the byte after the address loads an internal register pointer. Every later byte is stored at the pointed register, and the pointer then advances by one. A read transfer has no pointer phase. It returns data starting at the pointer where the last access left it, and the pointer advances after each byte sent. The block drives SDA only low, through an output enable, and a low-active select input can silence it completely. All register contents are visible at once on a flat output vector, so the surrounding logic reads its configuration directly.

The system clock must run at least 16 times faster than SCL. The bus may run at up to 400 kHz.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After a synchronous active-low reset every register reads 0x00 on `regs_flat` and `sda_oe` is 0 (SDA released).
- R2: A first byte after START whose upper seven bits equal 7'b1000000 is acknowledged by holding SDA low for the whole ninth SCL high period. Bit 0 of that byte selects the direction: 0 means write and 1 means read. `sda_oe` only rises while SCL is low.
- R3: A first byte with any other address is not acknowledged. SDA stays released for the rest of that transfer, no register changes, and the pointer keeps its value.
- R4: In a write, the second byte sets the pointer. Each following byte, MSB first, is stored at the pointer, acknowledged, and then the pointer increments.
- R5: The pointer increments modulo 256: after register 255 comes register 0, for writes and for reads.
- R6: A read returns the register at the current pointer MSB first, starting from where the previous write or read left the pointer. The pointer increments after every byte sent, including the last one.
- R7: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START. A STOP always releases SDA.
- R8: A START seen in the middle of a transfer (repeated START) releases SDA and returns the slave to receiving the address byte.
- R9: While `cs_n` is 1 the slave acknowledges nothing, writes no register and keeps SDA released.
- R10: Register k appears on `regs_flat[8k+7:8k]`, and a register changes only through an acknowledged write data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Low-active select; 1 silences the slave |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_flat | output | 2048 | All 256 registers, register k at bits 8k+7:8k |

## Verification
A wrong pointer is the most likely hidden fault. It shows up as data at the wrong register on `regs_flat` one cycle after the write byte's last SCL fall, or as a wrong byte on SDA at the first bit of the next read. A wrong byte-phase or address state shows at the ninth clock of the affected byte, as a missing or unexpected acknowledge. A stuck output enable shows as a host-observed low level on the next bit or at STOP. Random transfers run back to back and rely on the pointer value left by the previous transfer, so a fault in the pointer carries into every later check.

// File: rtl/i2c_rf_pkg.sv
// Package: shared types and constants of the register-file slave.
// Assumes byte-wide bus transfers; register width equals one bus byte.
package i2c_rf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_RX,      // shifting in a byte from the host
        ST_RX_ACK,  // driving acknowledge for a received byte
        ST_TX,      // shifting out a register byte
        ST_TX_ACK,  // listening to the host acknowledge
        ST_HOLD     // released, waiting for next START or STOP
    } slv_state_e;

    typedef enum logic [1:0] {
        PH_DEV,     // byte carries device address and direction
        PH_SUB,     // byte loads the register pointer
        PH_DATA     // byte carries register data
    } byte_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: two-flop synchronizer with edge detection for one bus line.
// Assumes the line idles high; reset loads the idle level so no edge
// is reported when reset is released.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Purpose: bring the line into the clock domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl_o  = sync_q;
    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/i2c_bus_cond.sv
// Module: START/STOP recognition from synchronized bus lines.
// Assumes SCL and SDA pass through equal synchronizer latency and the
// host never moves both lines in the same system-clock cycle.
module i2c_bus_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    // Purpose: an SDA edge while SCL is high is a bus condition.
    always_comb begin
        start_o = sda_fall & scl_lvl;
        stop_o  = sda_rise & scl_lvl;
    end
endmodule

// File: rtl/i2c_reg_array.sv
// Module: control register storage with one write port, one read port
// and a flat view of every entry. Assumes one write per cycle at most.
module i2c_reg_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [AW-1:0]           raddr,
    output logic [DW-1:0]           rdata,
    output logic [(2**AW)*DW-1:0]   flat_o
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: clear all entries on reset, store a byte on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_flat
            assign flat_o[g*DW +: DW] = mem[g];
        end
    endgenerate
endmodule

// File: rtl/i2c_slave_fsm.sv
// Module: byte engine of the slave: address match, pointer, shift
// registers, acknowledge generation and open-drain enable.
// Assumes edge strobes come from synchronized lines; outputs change only
// on a detected SCL fall, so SDA is never moved while SCL is high.
module i2c_slave_fsm
    import i2c_rf_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [6:0]  DEV_ADDR = 7'b1000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                sda_lvl,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [AW-1:0]       ptr_o,
    output logic                we_o,
    output logic [AW-1:0]       waddr_o,
    output logic [BYTE_W-1:0]   wdata_o,
    output logic                sda_oe_o
);
    localparam logic [AW-1:0] PTR_ONE  = AW'(1);
    localparam logic [3:0]    BITS_END = 4'd8;
    localparam logic [3:0]    LAST_TX  = 4'd7;

    slv_state_e          state;
    byte_phase_e         phase;
    logic                rd_mode;
    logic                host_ack;
    logic [3:0]          bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [AW-1:0]       ptr;

    // Purpose: sequence bits and bytes of each transfer and drive SDA enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_DEV;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            we_o     <= 1'b0;
            waddr_o  <= '0;
            wdata_o  <= '0;
            sda_oe_o <= 1'b0;
        end else begin
            we_o <= 1'b0;
            if (cs_n) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else if (start_det) begin
                state    <= ST_RX;
                phase    <= PH_DEV;
                rd_mode  <= 1'b0;
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise && bit_cnt < BITS_END) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS_END) begin
                            unique case (phase)
                                PH_DEV: begin
                                    if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                        rd_mode  <= shreg[0];
                                        phase    <= shreg[0] ? PH_DATA : PH_SUB;
                                        sda_oe_o <= 1'b1;
                                        state    <= ST_RX_ACK;
                                    end else begin
                                        state    <= ST_HOLD;
                                    end
                                end
                                PH_SUB: begin
                                    ptr      <= shreg[AW-1:0];
                                    phase    <= PH_DATA;
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_RX_ACK;
                                end
                                default: begin
                                    we_o     <= 1'b1;
                                    waddr_o  <= ptr;
                                    wdata_o  <= shreg;
                                    ptr      <= ptr + PTR_ONE;
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                shreg    <= rd_data;
                                sda_oe_o <= ~rd_data[BYTE_W-1];
                                state    <= ST_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_TX) begin
                                sda_oe_o <= 1'b0;
                                ptr      <= ptr + PTR_ONE;
                                host_ack <= 1'b0;
                                state    <= ST_TX_ACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~shreg[BYTE_W-2];
                                bit_cnt  <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                shreg    <= rd_data;
                                sda_oe_o <= ~rd_data[BYTE_W-1];
                                bit_cnt  <= '0;
                                state    <= ST_TX;
                            end else begin
                                state    <= ST_HOLD;
                            end
                        end
                    end
                    default: begin
                        sda_oe_o <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign ptr_o = ptr;
endmodule

// File: rtl/i2c_regfile_slave.sv
// Module: top of the I2C control register file slave.
// Assumes clk runs at least 16x SCL; SDA is open drain and sda_oe=1
// pulls it low. cs_n is treated as quasi-static.
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [6:0]  DEV_ADDR = 7'b1000000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_oe,
    output logic [(2**AW)*BYTE_W-1:0]    regs_flat
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] line_lvl;
    logic [N_LINES-1:0] line_rise;
    logic [N_LINES-1:0] line_fall;

    logic                start_det;
    logic                stop_det;
    logic                reg_we;
    logic [AW-1:0]       reg_waddr;
    logic [BYTE_W-1:0]   reg_wdata;
    logic [AW-1:0]       reg_ptr;
    logic [BYTE_W-1:0]   reg_rdata;

    assign raw_lines = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_sync
            i2c_line_sync u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (raw_lines[g]),
                .lvl_o  (line_lvl[g]),
                .rise_o (line_rise[g]),
                .fall_o (line_fall[g])
            );
        end
    endgenerate

    i2c_bus_cond u_cond (
        .scl_lvl  (line_lvl[0]),
        .sda_rise (line_rise[1]),
        .sda_fall (line_fall[1]),
        .start_o  (start_det),
        .stop_o   (stop_det)
    );

    i2c_slave_fsm #(
        .AW       (AW),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .scl_rise  (line_rise[0]),
        .scl_fall  (line_fall[0]),
        .sda_lvl   (line_lvl[1]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (reg_rdata),
        .ptr_o     (reg_ptr),
        .we_o      (reg_we),
        .waddr_o   (reg_waddr),
        .wdata_o   (reg_wdata),
        .sda_oe_o  (sda_oe)
    );

    i2c_reg_array #(
        .AW (AW),
        .DW (BYTE_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .waddr  (reg_waddr),
        .wdata  (reg_wdata),
        .raddr  (reg_ptr),
        .rdata  (reg_rdata),
        .flat_o (regs_flat)
    );
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
// Module: protocol checker bound to the register file slave.
// Assumes the host holds SCL low for several system clocks per bit.
module i2c_regfile_slave_chk #(
    parameter int AW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   scl_i,
    input  logic                   sda_oe,
    input  logic [(2**AW)*8-1:0]   regs_flat,
    input  logic                   reg_we,
    input  logic [AW-1:0]          reg_waddr,
    input  logic [7:0]             reg_wdata,
    input  logic                   start_det,
    input  logic                   stop_det
);
    logic          we_q;
    logic [AW-1:0] wa_q;
    logic [7:0]    wd_q;

    // Purpose: remember the last write request for the storage check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b0;
            wa_q <= '0;
            wd_q <= '0;
        end else begin
            we_q <= reg_we;
            wa_q <= reg_waddr;
            wd_q <= reg_wdata;
        end
    end

    assert_oe_rise_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> regs_flat[wa_q*8 +: 8] == wd_q);

    assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> !sda_oe);

    assert_restart_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    assert_deselect_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sda_oe);

    assert_deselect_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) |-> !reg_we);

    assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(regs_flat));
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_i2c_regfile_slave.sv
module test_i2c_regfile_slave;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'b1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [2047:0] regs_flat;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;

    always #4 clk = ~clk;

    i2c_regfile_slave i_i2c_regfile_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .scl_i(scl),
        .sda_i(sda_bus), .sda_oe(sda_oe), .regs_flat(regs_flat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        acked = ~sda_bus;
        wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl = 1'b0; wq(Q);
        end
        sda_m = ~give_ack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    // Compare every register slice k at [8k+7:8k] with the model (R10)
    task automatic cmp_regs(input string req);
        int bad = 0;
        for (int k = 0; k < 256; k++) begin
            if (regs_flat[k*8 +: 8] !== exp_mem[k]) bad++;
        end
        chk(req, bad, 0);
    endtask

    task automatic wr_txn(input logic [7:0] p, input int n);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R2 write address ack", a, 1);
        send_byte(p, a);           chk("R4 pointer byte ack", a, 1);
        exp_ptr = p;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, a); chk("R4 data byte ack", a, 1);
            exp_mem[exp_ptr] = d;
            exp_ptr = exp_ptr + 8'd1;
        end
        bus_stop();
        cmp_regs("R4 R10 register contents after write");
    endtask

    task automatic rd_txn(input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R2 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk("R6 read byte", b, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
        chk("R7 SDA released after host NACK", sda_oe, 0);
        chk("R7 bus high after host NACK", sda_bus, 1);
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 256; k++) exp_mem[k] = 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(5);
        cmp_regs("R1 registers zero after reset");
        chk("R1 SDA released after reset", sda_oe, 0);

        // Read straight after reset starts at pointer 0
        rd_txn(2);

        // Directed write then read back
        wr_txn(8'h10, 4);
        exp_ptr = 8'h10;
        bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h10, a); bus_stop();
        rd_txn(4);

        // Wrap of the pointer across 255 -> 0 (R5)
        wr_txn(8'hFE, 4);
        chk("R5 register 0 written after wrap", regs_flat[7:0], exp_mem[0]);
        exp_ptr = 8'hFF;
        bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'hFF, a); bus_stop();
        rd_txn(3);
        chk("R5 pointer wrapped on reads", exp_ptr, 8'h02);

        // Address mismatch: no ack, no write, pointer kept (R3)
        bus_start();
        send_byte({7'b1000001, 1'b0}, a); chk("R3 no ack for other address", a, 0);
        send_byte(8'h20, a);              chk("R3 no ack after mismatch", a, 0);
        send_byte(8'h5A, a);              chk("R3 no ack on data after mismatch", a, 0);
        bus_stop();
        cmp_regs("R3 registers unchanged after mismatch");
        rd_txn(1);

        // Repeated START mid-write returns to address phase (R8)
        bus_start();
        send_byte({DEV, 1'b0}, a); send_byte(8'h40, a);
        bus_start();
        chk("R8 SDA released at repeated START", sda_oe, 0);
        send_byte({DEV, 1'b0}, a); chk("R8 address ack after repeated START", a, 1);
        send_byte(8'h50, a);
        send_byte(8'hC3, a);
        bus_stop();
        exp_mem[8'h50] = 8'hC3; exp_ptr = 8'h51;
        cmp_regs("R8 write after repeated START");

        // Deselected: silent, no write (R9)
        cs_n = 1'b1;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R9 no ack while deselected", a, 0);
        send_byte(8'h60, a);
        send_byte(8'hEE, a);
        chk("R9 SDA released while deselected", sda_oe, 0);
        bus_stop();
        cs_n = 1'b0;
        cmp_regs("R9 registers unchanged while deselected");

        // Random mix of writes and reads from the running pointer
        for (int t = 0; t < 16; t++) begin
            if ($urandom_range(1, 0) == 1) wr_txn(8'($urandom), $urandom_range(6, 1));
            else rd_txn($urandom_range(5, 1));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule